// File: doc/BRIEF.md
# Four-Queue First-Word-Fall-Through Read Buffer

This block holds several independent first-in first-out queues in one shared storage array. All of them feed a single 36-bit read data output. A write port steers each incoming word into the queue named by its queue address. On the read side, a select strobe latches a new queue number from the read-address input. The head word of that queue then falls through to the output by itself. A read enable removes the word currently shown, and the next word in the same queue follows on the following cycle.

Choosing a queue never needs the read enable. After a select, the output shows the head of the chosen queue two clock edges later, without any pop. While the output holds no word, it keeps the last word it showed and drops its valid flag. Every queue reports its own empty and full status. Writes and reads share one clock and one synchronous active-high reset.

Top module: `mq_fwft_buf`

## Requirements
- R1: A reset empties every queue: after any edge with `rst` high, every `q_empty` bit is 1, every `q_full` bit is 0, `rd_valid` is 0, and queue 0 is the selected queue.
- R2: A write with `wr_en` high to a queue that is not full stores `wr_data` at that queue's tail. The queue's `q_empty` bit is 0 after that edge, and its `q_full` bit is 1 once it holds DEPTH words.
- R3: A write to a full queue is dropped. Its `q_full` bit stays 1, and a later drain returns only the DEPTH words stored before the drop.
- R4: Each queue returns its words in write order. Whenever `rd_valid` is 1, `rd_data` is the oldest word still held by the selected queue.
- R5: `rd_en` sampled high at an edge where `rd_valid` is 1 and `sel_stb` is 0 removes the shown word. The next word of the same queue is on `rd_data` after that edge, or `rd_valid` is 0 after that edge if the queue is now empty. A pop also clears the queue's `q_full` bit.
- R6: `sel_stb` sampled high at edge k makes `rd_q` the selected queue. `rd_valid` is 0 after edges k and k+1. After edge k+2, `rd_valid` is 1 with the new head on `rd_data` if that queue holds a word, whatever `rd_en` does. Selecting the queue that is already selected takes the same two edges.
- R7: `rd_en` has no effect at the select edge or during the two edges that follow. The first pop after a select can happen only at the edge after the new head is shown.
- R8: `rd_en` while `rd_valid` is 0 removes nothing. `rd_data` keeps the last word it showed, and `rd_valid` stays 0.
- R9: A word written into the empty selected queue at edge e is shown with `rd_valid` 1 after edge e+1.
- R10: Writes to queues that are not selected leave `rd_data`, `rd_valid` and the contents of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for writes and reads |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_q | input | $clog2(NUM_Q) | Queue receiving the write |
| wr_data | input | DATA_W | Word to write |
| sel_stb | input | 1 | Latches `rd_q` as the selected queue |
| rd_q | input | $clog2(NUM_Q) | Queue number taken on a select |
| rd_en | input | 1 | Pops the shown word of the selected queue |
| rd_data | output | DATA_W | Head word of the selected queue |
| rd_valid | output | 1 | `rd_data` holds a word that has not been popped |
| q_empty | output | NUM_Q | Per-queue empty flags |
| q_full | output | NUM_Q | Per-queue full flags |

## Verification
The bench builds the block with NUM_Q=4, DATA_W=36 and DEPTH=4. At that shallow depth a queue fills after four writes, so the full flag, the dropped overflow write and pointer wrap-around all come up within a few cycles of directed stimulus. During the random phase each queue wraps many times while selects, pops and writes collide on the same edge. A queue-per-channel model checks the order of the words and the per-queue flags against what the block reports.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

  // Read-side phase: normal running, or the blank edge after a select.
  typedef enum logic {
    RD_RUN    = 1'b0,
    RD_SWITCH = 1'b1
  } rd_phase_e;

endpackage

// File: rtl/mqf_ram.sv
// Simple dual-port storage: one write port, one registered read port with
// read enable. The read register keeps its word while the enable is low.
module mqf_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/mqf_ptr_bank.sv
// Per-queue head/tail pointers, fill levels and registered flags.
module mqf_ptr_bank #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 16,
  parameter int QA_W  = 2,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [QA_W-1:0]             wr_q,
  input  logic                        pop,
  input  logic [QA_W-1:0]             pop_q,
  output logic                        wr_accept,
  output logic [PTR_W-1:0]            wr_ptr,
  output logic [NUM_Q-1:0][PTR_W-1:0] rd_ptr,
  output logic [NUM_Q-1:0][CNT_W-1:0] level,
  output logic [NUM_Q-1:0]            empty,
  output logic [NUM_Q-1:0]            full
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_LVL  = CNT_W'(1);

  logic [NUM_Q-1:0][PTR_W-1:0] tail;

  assign wr_accept = wr_en && !full[wr_q];
  assign wr_ptr    = tail[wr_q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic             inc, dec;
    logic [PTR_W-1:0] tail_r, head_r;
    logic [CNT_W-1:0] lvl_r;
    logic             emp_r, ful_r;

    assign inc = wr_accept && (wr_q == QA_W'(g));
    assign dec = pop && (pop_q == QA_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        tail_r <= '0;
        head_r <= '0;
        lvl_r  <= '0;
        emp_r  <= 1'b1;
        ful_r  <= 1'b0;
      end else begin
        if (inc) tail_r <= tail_r + 1'b1;
        if (dec) head_r <= head_r + 1'b1;
        case ({inc, dec})
          2'b10: begin
            lvl_r <= lvl_r + 1'b1;
            emp_r <= 1'b0;
            ful_r <= (lvl_r + 1'b1) == FULL_LVL;
          end
          2'b01: begin
            lvl_r <= lvl_r - 1'b1;
            ful_r <= 1'b0;
            emp_r <= lvl_r == ONE_LVL;
          end
          default: ;
        endcase
      end
    end

    assign tail[g]   = tail_r;
    assign rd_ptr[g] = head_r;
    assign level[g]  = lvl_r;
    assign empty[g]  = emp_r;
    assign full[g]   = ful_r;
  end

endmodule

// File: rtl/mqf_rd_ctrl.sv
// Read-side control: queue selection, the two-edge switch window, pop
// acceptance and the storage read request that feeds the output register.
module mqf_rd_ctrl
  import mqf_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int QA_W  = 2,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sel_stb,
  input  logic [QA_W-1:0]             rd_q,
  input  logic                        rd_en,
  input  logic [NUM_Q-1:0][PTR_W-1:0] rd_ptr,
  input  logic [NUM_Q-1:0][CNT_W-1:0] level,
  output logic [QA_W-1:0]             sel_q,
  output logic                        pop,
  output logic                        ram_re,
  output logic [QA_W+PTR_W-1:0]       ram_raddr,
  output logic                        rd_valid
);

  rd_phase_e        phase;
  logic             busy;
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] left;

  // No read request at the select edge nor on the edge after it.
  assign busy      = sel_stb || (phase == RD_SWITCH);
  assign pop       = rd_en && rd_valid && !busy;
  assign head      = rd_ptr[sel_q] + PTR_W'(pop);
  assign left      = level[sel_q] - CNT_W'(pop);
  assign ram_re    = !busy && (left != '0);
  assign ram_raddr = {sel_q, head};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= RD_RUN;
      sel_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      phase    <= sel_stb ? RD_SWITCH : RD_RUN;
      if (sel_stb) sel_q <= rd_q;
      rd_valid <= ram_re;
    end
  end

endmodule

// File: rtl/mq_fwft_buf.sv
module mq_fwft_buf #(
  parameter int DATA_W = 36,
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NUM_Q)-1:0] wr_q,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     sel_stb,
  input  logic [$clog2(NUM_Q)-1:0] rd_q,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [NUM_Q-1:0]         q_empty,
  output logic [NUM_Q-1:0]         q_full
);

  localparam int QA_W   = $clog2(NUM_Q);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam int ADDR_W = QA_W + PTR_W;

  logic                        wr_accept;
  logic [PTR_W-1:0]            wr_ptr;
  logic [NUM_Q-1:0][PTR_W-1:0] head_ptr;
  logic [NUM_Q-1:0][CNT_W-1:0] level;
  logic [QA_W-1:0]             sel_q;
  logic                        rd_pop;
  logic                        ram_re;
  logic [ADDR_W-1:0]           ram_raddr;

  mqf_ptr_bank #(
    .NUM_Q(NUM_Q), .DEPTH(DEPTH), .QA_W(QA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_q     (wr_q),
    .pop      (rd_pop),
    .pop_q    (sel_q),
    .wr_accept(wr_accept),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (head_ptr),
    .level    (level),
    .empty    (q_empty),
    .full     (q_full)
  );

  mqf_rd_ctrl #(
    .NUM_Q(NUM_Q), .QA_W(QA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sel_stb  (sel_stb),
    .rd_q     (rd_q),
    .rd_en    (rd_en),
    .rd_ptr   (head_ptr),
    .level    (level),
    .sel_q    (sel_q),
    .pop      (rd_pop),
    .ram_re   (ram_re),
    .ram_raddr(ram_raddr),
    .rd_valid (rd_valid)
  );

  mqf_ram #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_accept),
    .waddr({wr_q, wr_ptr}),
    .wdata(wr_data),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/mqf_checker.sv
module mqf_checker #(
  parameter int NUM_Q  = 4,
  parameter int DATA_W = 36
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [$clog2(NUM_Q)-1:0] wr_q,
  input logic                     sel_stb,
  input logic                     rd_valid,
  input logic [DATA_W-1:0]        rd_data,
  input logic [NUM_Q-1:0]         q_empty,
  input logic [NUM_Q-1:0]         q_full,
  input logic [$clog2(NUM_Q)-1:0] sel_q,
  input logic                     rd_pop
);

  localparam int QA_W = $clog2(NUM_Q);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (q_empty == '1 && q_full == '0 && !rd_valid)); // R1

  AST_VALID_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !q_empty[sel_q]); // R4

  AST_SWITCH_BLANK: assert property (@(posedge clk) disable iff (rst)
    sel_stb |=> (!rd_valid ##1 !rd_valid)); // R6

  AST_WINDOW_NO_POP: assert property (@(posedge clk) disable iff (rst)
    sel_stb |=> !rd_pop); // R7

  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid ##1 !rd_valid) |-> $stable(rd_data)); // R8

  for (genvar i = 0; i < NUM_Q; i++) begin : g_flag
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
      (q_empty[i] && !(wr_en && wr_q == QA_W'(i))) |=> q_empty[i]); // R8
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
      (q_full[i] && !(rd_pop && sel_q == QA_W'(i))) |=> q_full[i]); // R3
  end

endmodule

bind mq_fwft_buf mqf_checker #(.NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_q    (wr_q),
  .sel_stb (sel_stb),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .q_empty (q_empty),
  .q_full  (q_full),
  .sel_q   (sel_q),
  .rd_pop  (rd_pop)
);

// File: tb/tb_mq_fwft_buf.sv
module tb_mq_fwft_buf;

  localparam int DW  = 36;
  localparam int NQ  = 4;
  localparam int DEP = 4;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_SEL = 2'd1;
  localparam logic [1:0] OP_POP = 2'd2;
  localparam logic [1:0] OP_EMP = 2'd3;

  // {op, queue, value}: value is write data, or the expected shown word.
  localparam int NVEC = 18;
  localparam logic [39:0] VEC [NVEC] = '{
    {OP_WR,  2'd1, 36'hA01}, {OP_WR,  2'd1, 36'hA02},
    {OP_WR,  2'd2, 36'hB01}, {OP_WR,  2'd1, 36'hA03},
    {OP_SEL, 2'd1, 36'hA01}, {OP_POP, 2'd1, 36'hA01},
    {OP_POP, 2'd1, 36'hA02}, {OP_WR,  2'd3, 36'hC01},
    {OP_SEL, 2'd2, 36'hB01}, {OP_POP, 2'd2, 36'hB01},
    {OP_EMP, 2'd2, 36'h0},   {OP_SEL, 2'd1, 36'hA03},
    {OP_POP, 2'd1, 36'hA03}, {OP_EMP, 2'd1, 36'h0},
    {OP_SEL, 2'd3, 36'hC01}, {OP_POP, 2'd3, 36'hC01},
    {OP_EMP, 2'd3, 36'h0},   {OP_EMP, 2'd0, 36'h0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, sel_stb = 1'b0, rd_en = 1'b0;
  logic [1:0]    wr_q = '0, rd_q = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [NQ-1:0] q_empty, q_full;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mq_fwft_buf #(.DATA_W(DW), .NUM_Q(NQ), .DEPTH(DEP)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .sel_stb(sel_stb), .rd_q(rd_q), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .q_empty(q_empty), .q_full(q_full)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic select(input logic [1:0] q);
    sel_stb = 1'b1; rd_q = q;
    tick();
    sel_stb = 1'b0;
  endtask

  // Scoreboard for the random phase
  logic [DW-1:0] mq [NQ][DEP];
  int mh [NQ];
  int mc [NQ];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0]    q;
    logic [DW-1:0] v;
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;
    // R1: reset state
    chk(q_empty == '1, "R1 empty after reset", q_empty, 4'hF);
    chk(q_full == '0, "R1 full after reset", q_full, 0);
    chk(!rd_valid, "R1 valid after reset", rd_valid, 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      q = VEC[i][37:36];
      v = VEC[i][35:0];
      case (VEC[i][39:38])
        OP_WR: begin
          wr_en = 1'b1; wr_q = q; wr_data = v;
          tick();
          wr_en = 1'b0;
          chk(!q_empty[q], "R2 empty drops on write", q_empty[q], 0);
        end
        OP_SEL: begin
          select(q);
          chk(!rd_valid, "R6 blank after select edge", rd_valid, 0);
          tick();
          chk(!rd_valid, "R6 blank one edge later", rd_valid, 0);
          tick();
          chk(rd_valid && rd_data == v, "R6 head shown two edges after select",
              rd_data, v);
        end
        OP_POP: begin
          chk(rd_valid && rd_data == v, "R4 word order", rd_data, v);
          rd_en = 1'b1;
          tick();
          rd_en = 1'b0;
        end
        default: begin
          chk(!rd_valid || q != dut.u_ctrl.sel_q ? q_empty[q] : 1'b0,
              "R5 queue drained", q_empty[q], 1);
        end
      endcase
    end
    chk(!rd_valid, "R5 valid low after last pop", rd_valid, 0);

    // Fill queue 0, overflow, drain
    select(2'd0); tick(); tick();
    wr_en = 1'b1; wr_q = 2'd0;
    wr_data = 36'hD00; tick();
    chk(!rd_valid, "R9 not shown one edge after write", rd_valid, 0);
    wr_data = 36'hD01; tick();
    chk(rd_valid && rd_data == 36'hD00, "R9 shown two edges after write",
        rd_data, 36'hD00);
    wr_data = 36'hD02; tick();
    wr_data = 36'hD03; tick();
    chk(q_full[0], "R2 full after DEPTH writes", q_full[0], 1);
    wr_data = 36'hDFF; tick();
    wr_en = 1'b0;
    chk(q_full[0], "R3 full stays after dropped write", q_full[0], 1);
    for (int k = 0; k < DEP; k++) begin
      chk(rd_valid && rd_data == 36'hD00 + k, "R3 drain returns stored words",
          rd_data, 36'hD00 + k);
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      if (k == 0) chk(!q_full[0], "R5 pop clears full", q_full[0], 0);
    end
    chk(!rd_valid && q_empty[0], "R3 overflow word not stored", rd_valid, 0);

    // rd_en across the switch window
    wr_en = 1'b1;
    wr_q = 2'd2; wr_data = 36'hE00; tick();
    wr_data = 36'hE01; tick();
    wr_q = 2'd0; wr_data = 36'hF00; tick();
    wr_en = 1'b0;
    tick();
    chk(rd_valid && rd_data == 36'hF00, "R9 queue 0 head shown", rd_data, 36'hF00);
    sel_stb = 1'b1; rd_q = 2'd2; rd_en = 1'b1;
    tick();
    sel_stb = 1'b0;
    tick(); tick();
    chk(rd_valid && rd_data == 36'hE00, "R7 no pop inside window", rd_data, 36'hE00);
    tick();
    rd_en = 1'b0;
    chk(rd_valid && rd_data == 36'hE01, "R5 first pop after window", rd_data, 36'hE01);
    chk(!q_empty[0], "R7 select edge did not pop old queue", q_empty[0], 0);

    // Pop on empty
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk(!rd_valid && rd_data == 36'hE01, "R8 last word held", rd_data, 36'hE01);
    rd_en = 1'b1; tick(); tick(); tick(); rd_en = 1'b0;
    chk(!rd_valid && rd_data == 36'hE01, "R8 empty pop has no effect",
        rd_data, 36'hE01);
    chk(q_empty[2] && !q_empty[0], "R8 flags unchanged by empty pop", q_empty, 4'hE);

    // Writes to other queues
    wr_en = 1'b1; wr_q = 2'd1;
    wr_data = 36'h600; tick();
    wr_data = 36'h601; tick();
    wr_en = 1'b0; tick();
    chk(!rd_valid && rd_data == 36'hE01, "R10 output untouched", rd_data, 36'hE01);
    chk(!q_empty[1], "R10 other queue stored", q_empty[1], 0);
    select(2'd0); tick(); tick();
    chk(rd_valid && rd_data == 36'hF00, "R10 queue 0 intact", rd_data, 36'hF00);

    // Reset while queues hold data
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk(q_empty == '1 && q_full == '0 && !rd_valid, "R1 mid-run reset",
        {q_full, q_empty, rd_valid}, 9'h1E);

    // Random traffic against the scoreboard
    for (int j = 0; j < NQ; j++) begin mh[j] = 0; mc[j] = 0; end
    begin
      int cur;
      cur = 0;
      for (int n = 0; n < 4000; n++) begin
        bit s, w, r, pexp, wacc;
        int wq, nq;
        logic [NQ-1:0] eemp, eful;
        logic [DW-1:0] d;
        s  = ($urandom % 12) == 0;
        w  = ($urandom % 2) == 1;
        r  = ($urandom % 2) == 1;
        wq = $urandom % NQ;
        nq = $urandom % NQ;
        d  = DW'({$urandom, $urandom});
        sel_stb = s; rd_q = nq[1:0];
        wr_en = w; wr_q = wq[1:0]; wr_data = d;
        rd_en = r;
        pexp = r && rd_valid && !s;
        if (rd_valid)
          chk(mc[cur] > 0, "R4 valid only on a held word", mc[cur], 1);
        if (pexp)
          chk(rd_data == mq[cur][mh[cur]], "R4 random order", rd_data,
              mq[cur][mh[cur]]);
        tick();
        wacc = w && (mc[wq] < DEP);
        if (wacc) begin
          mq[wq][(mh[wq] + mc[wq]) % DEP] = d;
          mc[wq]++;
        end
        if (pexp) begin
          mh[cur] = (mh[cur] + 1) % DEP;
          mc[cur]--;
        end
        if (s) cur = nq;
        for (int j = 0; j < NQ; j++) begin
          eemp[j] = mc[j] == 0;
          eful[j] = mc[j] == DEP;
        end
        chk(q_empty == eemp, "R2 random empty flags", q_empty, eemp);
        chk(q_full == eful, "R3 random full flags", q_full, eful);
      end
      sel_stb = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule